// File: doc/BRIEF.md
# Supervisor Address Segment Checker

This block forms a data address from a 64-bit base register and a 16-bit signed displacement. It then classifies the address against the fixed segment map that applies while the processor runs at the intermediate (supervisor) privilege level. For each accepted request it reports the effective address, a segment code, whether the address needs TLB translation, whether it is an address error, and whether the low 32-bit part of the sum overflowed in the two's-complement sense. A wide-mode select chooses between the 32-bit map and the 64-bit map. In the 32-bit map the address is sign-extended from bit 31 before it is decoded.

Requests enter on a valid/ready interface and results leave on a valid/ready interface, through a single register stage. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` from the next edge on. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. The privilege and mode fields are sampled together with the address operands.

Top module: `sms_seg_check`

## Requirements
- R1: The effective address is the base plus the displacement sign-extended from its bit 15, taken modulo 2^64. In wide mode (`wide_mode`=1) `res_ea` is this sum unchanged.
- R2: In 32-bit mode (`wide_mode`=0), `res_ea` is bits 31:0 of the sum, with bit 31 copied into bits 63:32.
- R3: `res_ovf32` is 1 when displacement bit 15 and base bit 31 are both 0 and sum bit 31 is 1. It is also 1 when displacement bit 15 and base bit 31 are both 1 and sum bit 31 is 0. It is 0 otherwise, in every mode.
- R4: In supervisor 32-bit mode the segment code is 1 for low word 0000_0000..7FFF_FFFF and 2 for low word C000_0000..DFFF_FFFF. Any other address is an error with code 0. A set `res_ovf32` also forces an error with code 0.
- R5: In supervisor wide mode the segment code depends only on the address. It is 3 for 0..0000_00FF_FFFF_FFFF, 4 for 4000_0000_0000_0000..4000_00FF_FFFF_FFFF and 5 for FFFF_FFFF_C000_0000..FFFF_FFFF_DFFF_FFFF. Any other address is an error with code 0.
- R6: Supervisor level means `priv_mode`=2'b01, `exc_level`=0 and `err_level`=0. At any other level `res_nosup`=1, the segment code is 0, and `res_mapped` and `res_addr_err` are both 0. At supervisor level `res_nosup`=0.
- R7: `res_mapped` is 1 exactly when the segment code is nonzero. It is never 1 together with `res_addr_err`.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. An accepted request shows its result on the next edge. A result that is not taken holds all of its fields stable.
- R9: A synchronous active-high `rst` clears `out_valid`, `res_seg`, `res_mapped`, `res_addr_err`, `res_ovf32` and `res_nosup`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| priv_mode | input | 2 | Privilege level field, 01 means supervisor |
| exc_level | input | 1 | Exception level bit |
| err_level | input | 1 | Error level bit |
| wide_mode | input | 1 | 1 selects the 64-bit map, 0 selects the 32-bit map |
| base_reg | input | 64 | Base register value |
| offset | input | 16 | Signed displacement |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result can be taken |
| res_ea | output | 64 | Effective address |
| res_seg | output | 3 | Segment code (0 none/error, 1..5 per R4/R5) |
| res_mapped | output | 1 | Address needs TLB translation |
| res_addr_err | output | 1 | Address error |
| res_ovf32 | output | 1 | 32-bit signed overflow of base plus displacement |
| res_nosup | output | 1 | Request was not at supervisor level |

## Verification
The block has one result register, so a wrong internal state shows at the ports on the cycle right after the request is accepted. A wrong decode boundary shows as a wrong segment code or error bit, and a dropped sign extension shows as wrong upper bits of the address. A fault in the hold logic shows as fields that change while `out_ready` is low, or as an `in_ready` that disagrees with the handshake rule in the same cycle. The bench aims at the edges of every segment, at both overflow cases, and at each privilege combination that is not supervisor, and it throttles `out_ready` at random.

// File: rtl/sms_pkg.sv
package sms_pkg;
  localparam int ADDR_W   = 64;
  localparam int DISP_W   = 16;
  localparam int NARROW_W = 32;
  localparam int SEG_CW   = 3;
  // 1 TB wide segments: bits above this index select the region
  localparam int WIDE_SEG_BITS = 40;
  // 0.5 GB compatibility window: bits above this index select it
  localparam int HALF_GB_BITS  = 29;

  typedef enum logic [SEG_CW-1:0] {
    SEG_NONE   = 3'd0,
    SEG_USR32  = 3'd1,
    SEG_SUP32  = 3'd2,
    SEG_USR64  = 3'd3,
    SEG_SUP64  = 3'd4,
    SEG_CSUP   = 3'd5
  } seg_code_e;

  typedef struct packed {
    logic [ADDR_W-1:0] ea;
    seg_code_e         seg;
    logic              mapped;
    logic              addr_err;
    logic              ovf32;
    logic              nosup;
  } seg_result_t;
endpackage

// File: rtl/sms_addr_gen.sv
module sms_addr_gen #(
  parameter int AW = 64,
  parameter int DW = 16,
  parameter int NW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] disp,
  input  logic          wide,
  output logic [AW-1:0] ea,
  output logic          ovf
);
  localparam int EXT_W = AW - DW;
  localparam int UP_W  = AW - NW;

  logic [AW-1:0] disp_x;
  logic [AW-1:0] sum;

  always_comb begin
    disp_x = {{EXT_W{disp[DW-1]}}, disp};
    sum    = base + disp_x;
    ovf    = (!disp[DW-1] && !base[NW-1] &&  sum[NW-1]) ||
             ( disp[DW-1] &&  base[NW-1] && !sum[NW-1]);
    ea     = wide ? sum : {{UP_W{sum[NW-1]}}, sum[NW-1:0]};
  end
endmodule

// File: rtl/sms_seg_decode.sv
module sms_seg_decode
  import sms_pkg::*;
#(
  parameter int AW = 64,
  parameter int NW = 32,
  parameter int WB = 40,
  parameter int HB = 29
) (
  input  logic [AW-1:0] ea,
  input  logic          wide,
  input  logic          sup,
  input  logic          ovf,
  output seg_code_e     seg,
  output logic          err
);
  localparam int TOP_W  = AW - WB;
  localparam int HI_W   = AW - HB;
  localparam logic [TOP_W-1:0] TOP_USR = '0;
  localparam logic [TOP_W-1:0] TOP_SUP = {2'b01, {(TOP_W-2){1'b0}}};
  localparam logic [HI_W-1:0]  HI_CSUP = {{(HI_W-3){1'b1}}, 3'b110};

  logic [NW-1:0] lo;
  seg_code_e     hit;

  always_comb begin
    lo  = ea[NW-1:0];
    hit = SEG_NONE;
    if (!wide) begin
      if (ovf)                      hit = SEG_NONE;
      else if (!lo[NW-1])           hit = SEG_USR32;
      else if (lo[NW-1:HB] == 3'b110) hit = SEG_SUP32;
    end else begin
      if (ea[AW-1:WB] == TOP_USR)      hit = SEG_USR64;
      else if (ea[AW-1:WB] == TOP_SUP) hit = SEG_SUP64;
      else if (ea[AW-1:HB] == HI_CSUP) hit = SEG_CSUP;
    end
    seg = sup ? hit : SEG_NONE;
    err = sup && (hit == SEG_NONE);
  end

  always_comb begin
    if (!sup) a_r6_quiet_decode: assert (seg == SEG_NONE && !err);
  end
endmodule

// File: rtl/sms_seg_check.sv
module sms_seg_check
  import sms_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          priv_mode,
  input  logic                exc_level,
  input  logic                err_level,
  input  logic                wide_mode,
  input  logic [ADDR_W-1:0]   base_reg,
  input  logic [DISP_W-1:0]   offset,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [ADDR_W-1:0]   res_ea,
  output logic [SEG_CW-1:0]   res_seg,
  output logic                res_mapped,
  output logic                res_addr_err,
  output logic                res_ovf32,
  output logic                res_nosup
);
  logic [ADDR_W-1:0] ea_c;
  logic              ovf_c;
  logic              sup_c;
  seg_code_e         seg_c;
  logic              err_c;
  seg_result_t       res_q;
  logic              valid_q;
  logic              wide_q;

  assign sup_c = (priv_mode == 2'b01) && !exc_level && !err_level;

  sms_addr_gen #(.AW(ADDR_W), .DW(DISP_W), .NW(NARROW_W)) u_gen (
    .base (base_reg),
    .disp (offset),
    .wide (wide_mode),
    .ea   (ea_c),
    .ovf  (ovf_c)
  );

  sms_seg_decode #(.AW(ADDR_W), .NW(NARROW_W), .WB(WIDE_SEG_BITS),
                   .HB(HALF_GB_BITS)) u_dec (
    .ea   (ea_c),
    .wide (wide_mode),
    .sup  (sup_c),
    .ovf  (ovf_c),
    .seg  (seg_c),
    .err  (err_c)
  );

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      wide_q  <= 1'b0;
      res_q   <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        wide_q         <= wide_mode;
        res_q.ea       <= ea_c;
        res_q.seg      <= seg_c;
        res_q.mapped   <= (seg_c != SEG_NONE);
        res_q.addr_err <= err_c;
        res_q.ovf32    <= ovf_c;
        res_q.nosup    <= !sup_c;
      end
    end
  end

  assign out_valid    = valid_q;
  assign res_ea       = res_q.ea;
  assign res_seg      = res_q.seg;
  assign res_mapped   = res_q.mapped;
  assign res_addr_err = res_q.addr_err;
  assign res_ovf32    = res_q.ovf32;
  assign res_nosup    = res_q.nosup;

  a_r7_mapped_no_err: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(res_mapped && res_addr_err));
  a_r6_nosup_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_nosup) |-> (res_seg == 3'd0 && !res_mapped && !res_addr_err));
  a_r8_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_ea) && $stable(res_seg)
                                   && $stable(res_addr_err)));
  a_r2_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_q) |-> (res_ea[ADDR_W-1:NARROW_W] == {(ADDR_W-NARROW_W){res_ea[NARROW_W-1]}}));
  a_r4_ovf_forces_err: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_q && !res_nosup && res_ovf32) |-> res_addr_err);
endmodule

// File: tb/sms_seg_check_tb.sv
module sms_seg_check_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  priv_mode = 2'b01;
  logic        exc_level = 1'b0;
  logic        err_level = 1'b0;
  logic        wide_mode = 1'b0;
  logic [63:0] base_reg = '0;
  logic [15:0] offset = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] res_ea;
  logic [2:0]  res_seg;
  logic        res_mapped, res_addr_err, res_ovf32, res_nosup;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sms_seg_check dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .priv_mode(priv_mode), .exc_level(exc_level), .err_level(err_level),
    .wide_mode(wide_mode), .base_reg(base_reg), .offset(offset),
    .out_valid(out_valid), .out_ready(out_ready), .res_ea(res_ea),
    .res_seg(res_seg), .res_mapped(res_mapped), .res_addr_err(res_addr_err),
    .res_ovf32(res_ovf32), .res_nosup(res_nosup)
  );

  typedef struct {
    logic [63:0] ea;
    int          seg;
    bit          mapped, err, ovf, nosup, wide;
  } exp_t;

  function automatic exp_t model(logic [1:0] pm, bit ex, bit er, bit wd,
                                 logic [63:0] b, logic [15:0] d);
    exp_t r;
    logic [63:0] s;
    logic [63:0] dx;
    dx = {{48{d[15]}}, d};
    s  = b + dx;
    r.wide = wd;
    r.ovf = (d[15] == 1'b0 && b[31] == 1'b0 && s[31] == 1'b1) ||
            (d[15] == 1'b1 && b[31] == 1'b1 && s[31] == 1'b0);
    r.ea = wd ? s : {{32{s[31]}}, s[31:0]};
    r.nosup = !(pm == 2'b01 && !ex && !er);
    r.seg = 0;
    if (!r.nosup) begin
      if (!wd) begin
        if (r.ovf) r.seg = 0;
        else if (r.ea[31:0] <= 32'h7FFF_FFFF) r.seg = 1;
        else if (r.ea[31:0] >= 32'hC000_0000 && r.ea[31:0] <= 32'hDFFF_FFFF) r.seg = 2;
      end else begin
        if (r.ea <= 64'h0000_00FF_FFFF_FFFF) r.seg = 3;
        else if (r.ea >= 64'h4000_0000_0000_0000 && r.ea <= 64'h4000_00FF_FFFF_FFFF) r.seg = 4;
        else if (r.ea >= 64'hFFFF_FFFF_C000_0000 && r.ea <= 64'hFFFF_FFFF_DFFF_FFFF) r.seg = 5;
      end
    end
    r.mapped = (r.seg != 0);
    r.err    = !r.nosup && (r.seg == 0);
    return r;
  endfunction

  // behavioural model of the output stage
  bit   m_valid = 0;
  bit   m_acc = 0;
  exp_t m_res;

  always @(posedge clk) begin
    m_acc = 0;
    if (rst) m_valid = 0;
    else if (!m_valid || out_ready) begin
      m_valid = in_valid;
      if (in_valid) begin
        m_res = model(priv_mode, exc_level, err_level, wide_mode, base_reg, offset);
        m_acc = 1;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic compare();
    chk(out_valid == m_valid, "R8", "out_valid", 64'(out_valid), 64'(m_valid));
    if (out_valid && m_valid) begin
      chk(res_ea == m_res.ea, m_res.wide ? "R1" : "R2", "ea", res_ea, m_res.ea);
      chk(res_ovf32 == m_res.ovf, "R3", "ovf32", 64'(res_ovf32), 64'(m_res.ovf));
      chk(int'(res_seg) == m_res.seg,
          m_res.nosup ? "R6" : (m_res.wide ? "R5" : "R4"), "seg",
          64'(res_seg), 64'(m_res.seg));
      chk(res_nosup == m_res.nosup, "R6", "nosup", 64'(res_nosup), 64'(m_res.nosup));
      chk(res_mapped == m_res.mapped, "R7", "mapped", 64'(res_mapped), 64'(m_res.mapped));
      chk(res_addr_err == m_res.err, m_res.wide ? "R5" : "R4", "addr_err",
          64'(res_addr_err), 64'(m_res.err));
    end
  endtask

  // directed vectors: {pm, ex, er, wide, base, disp}
  typedef struct { logic [1:0] pm; bit ex, er, wd; logic [63:0] b; logic [15:0] d; } vec_t;
  vec_t dirs[$];

  function automatic vec_t mk(logic [1:0] pm, bit ex, bit er, bit wd,
                              logic [63:0] b, logic [15:0] d);
    vec_t v;
    v.pm = pm; v.ex = ex; v.er = er; v.wd = wd; v.b = b; v.d = d;
    return v;
  endfunction

  function automatic logic [63:0] pick_base();
    logic [63:0] seeds [8];
    seeds[0] = 64'h0;
    seeds[1] = 64'h0000_0000_7FFF_FFF8;
    seeds[2] = 64'hFFFF_FFFF_C000_0000;
    seeds[3] = 64'hFFFF_FFFF_E000_0000;
    seeds[4] = 64'h0000_00FF_FFFF_FFF8;
    seeds[5] = 64'h4000_0000_0000_0000;
    seeds[6] = 64'h4000_00FF_FFFF_FFF8;
    seeds[7] = 64'hFFFF_FFFF_8000_0000;
    if ($urandom_range(0, 3) == 0) return {$urandom, $urandom};
    return seeds[$urandom_range(0, 7)];
  endfunction

  initial begin : stim
    vec_t cur;
    int   n_sent;
    // R1/R2/R4 32-bit cases
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'h0, 16'h0005));
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'h0000_0000_7FFF_FFF0, 16'h000F));
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'h0000_0000_7FFF_FFF0, 16'h0020)); // R3 case a
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'hFFFF_FFFF_8000_0000, 16'hFFFF)); // R3 case b
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'hFFFF_FFFF_C000_0010, 16'hFFF0));
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'hFFFF_FFFF_DFFF_FFF0, 16'h000F));
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'hFFFF_FFFF_DFFF_FFF0, 16'h0010));
    dirs.push_back(mk(2'b01, 0, 0, 0, 64'h1234_0000_0000_0100, 16'h8000));
    // R5 wide cases
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'h0000_00FF_FFFF_FFF0, 16'h000F));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'h0000_00FF_FFFF_FFF0, 16'h0010));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'h4000_0000_0000_0000, 16'h0000));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'h4000_0000_0000_0000, 16'hFFFF));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'h4000_00FF_FFFF_FFFF, 16'h0001));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'hFFFF_FFFF_C000_0000, 16'h0000));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'hFFFF_FFFF_DFFF_FFFF, 16'h0001));
    dirs.push_back(mk(2'b01, 0, 0, 1, 64'h0000_0000_7FFF_FFF0, 16'h0020));
    // R6 not supervisor
    dirs.push_back(mk(2'b00, 0, 0, 0, 64'h0, 16'h0004));
    dirs.push_back(mk(2'b10, 0, 0, 1, 64'h4000_0000_0000_0000, 16'h0));
    dirs.push_back(mk(2'b01, 1, 0, 0, 64'h0, 16'h0));
    dirs.push_back(mk(2'b01, 0, 1, 1, 64'h0, 16'h0));
    dirs.push_back(mk(2'b11, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0));

    repeat (3) @(negedge clk);
    // R9: reset state
    total++;
    if (out_valid || res_seg != 0 || res_mapped || res_addr_err || res_ovf32 || res_nosup) begin
      bad++;
      $display("FAIL R9 reset state actual=%b%0d%b%b%b%b expected=000000",
               out_valid, res_seg, res_mapped, res_addr_err, res_ovf32, res_nosup);
    end
    rst = 1'b0;
    n_sent = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      compare();
      out_ready = (cyc < 40) ? 1'b1 : ($urandom_range(0, 3) != 0);
      #1;
      chk(in_ready == (!m_valid || out_ready), "R8", "in_ready",
          64'(in_ready), 64'(!m_valid || out_ready));
      if (!in_valid || m_acc) begin
        if (cyc > 2900) in_valid = 1'b0;
        else if (dirs.size() != 0) begin
          cur = dirs.pop_front();
          in_valid = 1'b1;
        end else if ($urandom_range(0, 4) == 0) in_valid = 1'b0;
        else begin
          cur = mk(($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b01,
                   $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                   $urandom_range(0, 1) == 1, pick_base(), 16'($urandom));
          in_valid = 1'b1;
        end
        if (in_valid) begin
          priv_mode = cur.pm; exc_level = cur.ex; err_level = cur.er;
          wide_mode = cur.wd; base_reg = cur.b; offset = cur.d;
          n_sent++;
        end
      end
    end
    // R9: reset mid-run clears a pending result
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid || res_seg != 0 || res_mapped || res_addr_err || res_ovf32 || res_nosup) begin
      bad++;
      $display("FAIL R9 reset after traffic actual=%b expected=0", out_valid);
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule